// File: doc/BRIEF.md
# Random-Lock Serial Frame Aligner

The aligner sits behind a bit-clock recovery front end. It takes a serial stream one bit per enabled clock cycle and finds the 12-bit frame boundary. It needs no special training sequence. Each frame carries a high start bit, ten payload bits and a low stop bit. The boundary is therefore a low bit followed by a high bit at a fixed offset. The block scores every one of the twelve offsets independently. It commits to an offset only when that offset alone has kept a clean boundary long enough. While a repetitive payload keeps a second 0→1 edge alive at another offset, the block refuses to lock.

Once aligned, the block delivers each payload word with a one-cycle strobe. It tolerates short bursts of damaged boundaries. It drops lock after a run of bad frames and then restarts the whole search. An output-enable input and a run (powerdown) input gate the outputs. A polarity input selects whether the strobe is a high pulse or a low pulse.

Top module: `rla_frame_aligner`

## Requirements
- R1: `lock_n` is 1 after reset and while searching. On a stream with a single clean boundary offset, `lock_n` falls after the boundary bit of the 9th consecutive valid frame: the offset's counter saturates at 8, and one more valid boundary is then needed.
- R2: A frame is 12 bits in arrival order: start (1), payload bits 0..9, stop (0). A boundary is valid at an offset when the bit taken there is 1 and the bit taken just before it is 0. The first bit after reset or run-up is treated as preceded by a 0.
- R3: While more than one offset has a saturated counter, lock is withheld. Once the competing offset breaks, lock is taken at the next valid boundary of the survivor.
- R4: A stream with non-repeating pseudo-random payloads also acquires lock. It never does so before its 9th valid boundary.
- R5: While locked, three consecutive frames with an invalid boundary keep lock. A valid boundary clears the run. The fourth consecutive invalid boundary releases lock on that bit.
- R6: After loss of lock, every offset counter is cleared, so relocking needs nine fresh valid frames.
- R7: While locked, the payload of each frame appears on `word` at the boundary bit of the following frame, with payload bit 0 in `word[0]`. The strobe is asserted for exactly one cycle per frame.
- R8: While `lock_n` is 1, `word` is 0 and `wstb` is 0.
- R9: With `out_en` low, `word` is 0 and `wstb` is 0, while `lock_n` still shows the alignment state.
- R10: With `pwr_up` low, the aligner clears all state, `lock_n` is 1 and the other outputs are 0. Stream bits are ignored. Raising `pwr_up` starts a full search.
- R11: With `edge_rise` = 1 the strobe is a high pulse on a low idle level. With `edge_rise` = 0 it is a low pulse on a high idle level, when outputs are enabled and locked.
- R12: Bits are taken only in cycles where `bit_en` is 1. `ser_bit` is ignored in other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up | input | 1 | Run enable; low stops the aligner and blanks outputs |
| out_en | input | 1 | Output enable for `word` and `wstb` |
| edge_rise | input | 1 | Strobe polarity: 1 high pulse, 0 low pulse |
| bit_en | input | 1 | Qualifies `ser_bit` in this cycle |
| ser_bit | input | 1 | Serial stream bit |
| lock_n | output | 1 | Active-low alignment flag |
| word | output | 10 | Recovered payload word |
| wstb | output | 1 | Word strobe |

## Verification
Sync frames hold exactly one 0→1 edge per frame. They pin the lock instant to the ninth frame and so separate the saturation count from the confirmation frame. A stream with payload bits 4 and 5 held at 0 and 1 keeps two offsets saturated. It shows that lock is withheld, and switching to sync frames shows that lock comes exactly one frame after the rival offset breaks. Pseudo-random payloads and a list of distinct words check random acquisition and bit order. Garbage is driven on idle bit cycles. Frames with no start bit run the loss count up to three and then four, which separates tolerance from release.

// File: rtl/rla_pkg.sv
`timescale 1ns/1ps
package rla_pkg;
    localparam int unsigned FRAME_BITS = 12;
    localparam int unsigned CONF_LIMIT = 8;
    localparam int unsigned LOSS_LIMIT = 4;

    typedef enum logic {
        AL_HUNT  = 1'b0,
        AL_TRACK = 1'b1
    } align_state_e;

    typedef struct packed {
        logic tick;
        logic edge_ok;
    } bit_evt_t;

    function automatic logic at_last(input int unsigned pos, input int unsigned len);
        return pos == len - 1;
    endfunction
endpackage

// File: rtl/rla_bit_tracker.sv
`timescale 1ns/1ps
module rla_bit_tracker
    import rla_pkg::*;
#(
    parameter int unsigned FRAME_LEN = FRAME_BITS,
    localparam int unsigned POS_W = $clog2(FRAME_LEN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 bit_en,
    input  logic                 ser_bit,
    output bit_evt_t             evt,
    output logic [POS_W-1:0]     pos,
    output logic [FRAME_LEN-1:0] hist
);
    logic prev_q;

    always_comb begin
        evt.tick    = run & bit_en;
        evt.edge_ok = ~prev_q & ser_bit;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos    <= '0;
            prev_q <= 1'b0;
            hist   <= '0;
        end else if (evt.tick) begin
            pos    <= at_last(int'(pos), FRAME_LEN) ? '0 : pos + 1'b1;
            prev_q <= ser_bit;
            hist   <= {hist[FRAME_LEN-2:0], ser_bit};
        end
    end
endmodule

// File: rtl/rla_conf_bank.sv
`timescale 1ns/1ps
module rla_conf_bank
    import rla_pkg::*;
#(
    parameter int unsigned FRAME_LEN = FRAME_BITS,
    parameter int unsigned CONF_MAX  = CONF_LIMIT,
    localparam int unsigned POS_W = $clog2(FRAME_LEN),
    localparam int unsigned CNT_W = $clog2(CONF_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  bit_evt_t             evt,
    input  logic [POS_W-1:0]     pos,
    output logic [FRAME_LEN-1:0] sat
);
    for (genvar k = 0; k < FRAME_LEN; k++) begin : g_off
        logic [CNT_W-1:0] cnt;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                cnt <= '0;
            end else if (evt.tick && pos == POS_W'(k)) begin
                if (!evt.edge_ok) begin
                    cnt <= '0;
                end else if (cnt != CNT_W'(CONF_MAX)) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end

        assign sat[k] = (cnt == CNT_W'(CONF_MAX));
    end
endmodule

// File: rtl/rla_lock_ctl.sv
`timescale 1ns/1ps
module rla_lock_ctl
    import rla_pkg::*;
#(
    parameter int unsigned FRAME_LEN = FRAME_BITS,
    parameter int unsigned LOSS_MAX  = LOSS_LIMIT,
    localparam int unsigned POS_W = $clog2(FRAME_LEN),
    localparam int unsigned PAY_W = FRAME_LEN - 2,
    localparam int unsigned BAD_W = $clog2(LOSS_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  bit_evt_t             evt,
    input  logic [POS_W-1:0]     pos,
    input  logic [FRAME_LEN-1:0] hist,
    input  logic [FRAME_LEN-1:0] sat,
    output logic                 locked,
    output logic                 drop,
    output logic [PAY_W-1:0]     word_q,
    output logic                 vld_q
);
    align_state_e     st;
    logic [POS_W-1:0] anchor;
    logic [BAD_W-1:0] bad;
    logic [PAY_W-1:0] pay;
    logic             on_anchor;
    logic             acquire;

    // Oldest stored bit is the start bit; payload bit 0 follows it.
    always_comb begin
        for (int i = 0; i < PAY_W; i++) begin
            pay[i] = hist[FRAME_LEN-2-i];
        end
    end

    assign on_anchor = (st == AL_TRACK) && evt.tick && (pos == anchor);
    assign acquire   = (st == AL_HUNT) && evt.tick && evt.edge_ok
                       && sat[pos] && ($countones(sat) == 1);
    assign drop      = on_anchor && !evt.edge_ok && (bad == BAD_W'(LOSS_MAX - 1));
    assign locked    = (st == AL_TRACK);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            st     <= AL_HUNT;
            anchor <= '0;
            bad    <= '0;
            word_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= on_anchor;
            if (on_anchor) begin
                word_q <= pay;
            end
            if (acquire) begin
                st     <= AL_TRACK;
                anchor <= pos;
                bad    <= '0;
            end else if (on_anchor) begin
                if (evt.edge_ok) begin
                    bad <= '0;
                end else if (drop) begin
                    st  <= AL_HUNT;
                    bad <= '0;
                end else begin
                    bad <= bad + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rla_frame_aligner.sv
`timescale 1ns/1ps
module rla_frame_aligner
    import rla_pkg::*;
#(
    parameter int unsigned FRAME_LEN = FRAME_BITS,
    parameter int unsigned CONF_MAX  = CONF_LIMIT,
    parameter int unsigned LOSS_MAX  = LOSS_LIMIT,
    localparam int unsigned PAY_W = FRAME_LEN - 2,
    localparam int unsigned POS_W = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_up,
    input  logic             out_en,
    input  logic             edge_rise,
    input  logic             bit_en,
    input  logic             ser_bit,
    output logic             lock_n,
    output logic [PAY_W-1:0] word,
    output logic             wstb
);
    bit_evt_t             evt;
    logic [POS_W-1:0]     pos;
    logic [FRAME_LEN-1:0] hist;
    logic [FRAME_LEN-1:0] sat;
    logic                 locked;
    logic                 drop;
    logic [PAY_W-1:0]     word_q;
    logic                 vld_q;
    logic                 show;

    rla_bit_tracker #(.FRAME_LEN(FRAME_LEN)) u_trk (
        .clk(clk), .rst(rst), .run(pwr_up), .bit_en(bit_en), .ser_bit(ser_bit),
        .evt(evt), .pos(pos), .hist(hist)
    );

    rla_conf_bank #(.FRAME_LEN(FRAME_LEN), .CONF_MAX(CONF_MAX)) u_bank (
        .clk(clk), .rst(rst), .clr(drop | ~pwr_up), .evt(evt), .pos(pos), .sat(sat)
    );

    rla_lock_ctl #(.FRAME_LEN(FRAME_LEN), .LOSS_MAX(LOSS_MAX)) u_ctl (
        .clk(clk), .rst(rst), .run(pwr_up), .evt(evt), .pos(pos), .hist(hist),
        .sat(sat), .locked(locked), .drop(drop), .word_q(word_q), .vld_q(vld_q)
    );

    assign show   = locked & pwr_up & out_en;
    assign lock_n = ~(locked & pwr_up);
    assign word   = show ? word_q : '0;
    assign wstb   = show & (edge_rise ? vld_q : ~vld_q);
endmodule

// File: rtl/rla_frame_aligner_chk.sv
`timescale 1ns/1ps
module rla_frame_aligner_chk #(
    parameter int unsigned PAY_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             pwr_up,
    input logic             out_en,
    input logic             edge_rise,
    input logic             bit_en,
    input logic             ser_bit,
    input logic             lock_n,
    input logic [PAY_W-1:0] word,
    input logic             wstb
);
    logic strobe_now;
    assign strobe_now = out_en && !lock_n && (edge_rise ? wstb : !wstb);

    p_lock_on_bit_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_n) |-> ($past(bit_en) && $past(pwr_up)));

    p_loss_on_bit_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(lock_n) && pwr_up && $past(pwr_up)) |-> $past(bit_en));

    p_single_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        strobe_now |=> !strobe_now);

    p_word_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_en && !lock_n && $past(out_en && !lock_n) && !strobe_now) |-> $stable(word));

    p_unlocked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        lock_n |-> (word == '0 && !wstb));

    p_oe_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (word == '0 && !wstb));

    p_run_restart_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_up) |-> lock_n);
endmodule

bind rla_frame_aligner rla_frame_aligner_chk #(.PAY_W(PAY_W)) u_chk (
    .clk(clk), .rst(rst), .pwr_up(pwr_up), .out_en(out_en), .edge_rise(edge_rise),
    .bit_en(bit_en), .ser_bit(ser_bit), .lock_n(lock_n), .word(word), .wstb(wstb)
);

// File: tb/rla_frame_aligner_bench.sv
`timescale 1ns/1ps
module rla_frame_aligner_bench;
    localparam logic [9:0] SYNC = 10'h01F;  // payload bits 0..4 high, 5..9 low
    localparam logic [9:0] RMT  = 10'h3E0;  // bit 4 low, bit 5 high: second 0->1 edge

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_up = 1'b1;
    logic       out_en = 1'b1;
    logic       edge_rise = 1'b1;
    logic       bit_en = 1'b0;
    logic       ser_bit = 1'b0;
    logic       lock_n;
    logic [9:0] word;
    logic       wstb;

    int         total = 0;
    int         fails = 0;
    int         gcnt = 0;
    logic [9:0] got [64];
    logic [9:0] lf = 10'h1A3;

    always #2.5 clk = ~clk;

    rla_frame_aligner u_rla_frame_aligner (
        .clk(clk), .rst(rst), .pwr_up(pwr_up), .out_en(out_en), .edge_rise(edge_rise),
        .bit_en(bit_en), .ser_bit(ser_bit), .lock_n(lock_n), .word(word), .wstb(wstb)
    );

    always @(posedge clk) begin
        #1;
        if (!rst && (edge_rise ? wstb : (out_en && !lock_n && !wstb))) begin
            if (gcnt < 64) got[gcnt] = word;
            gcnt = gcnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Garbage on idle cycles exercises R12.
    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_bit = b;
        bit_en  = 1'b1;
        @(negedge clk);
        bit_en  = 1'b0;
        ser_bit = ~b;
    endtask

    task automatic send_frame(input logic [9:0] p, input logic st = 1'b1, input logic sp = 1'b0);
        send_bit(st);
        for (int i = 0; i < 10; i++) send_bit(p[i]);
        send_bit(sp);
    endtask

    task automatic send_frames(input logic [9:0] p, input int n);
        for (int i = 0; i < n; i++) send_frame(p);
    endtask

    task automatic next_lf();
        lf = {lf[8:0], lf[9] ^ lf[6]};
    endtask

    task automatic power_cycle();
        @(negedge clk);
        pwr_up = 1'b0;
        repeat (3) @(negedge clk);
        pwr_up = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 reset lock_n", lock_n, 1);
        chk("R8 reset word", word, 0);
        chk("R8 reset wstb", wstb, 0);
    endtask

    task automatic t_sync_lock();
        send_frames(SYNC, 8);
        chk("R1 no lock after 8 frames", lock_n, 1);
        chk("R8 word blank while hunting", word, 0);
        send_frame(SYNC);
        chk("R1 R2 lock on 9th frame", lock_n, 0);
    endtask

    task automatic t_words();
        logic [9:0] v [6];
        v[0] = 10'h2A5; v[1] = 10'h13C; v[2] = 10'h3FF;
        v[3] = 10'h000; v[4] = 10'h155; v[5] = 10'h0F0;
        gcnt = 0;
        for (int i = 0; i < 6; i++) send_frame(v[i]);
        chk("R7 one strobe per frame", gcnt, 6);
        for (int k = 1; k < 6; k++) chk("R7 R12 word order", got[k], v[k-1]);
        chk("R7 strobe idle low", wstb, 0);
    endtask

    task automatic t_edge();
        edge_rise = 1'b0;
        @(negedge clk);
        chk("R11 idle level high", wstb, 1);
        gcnt = 0;
        send_frames(SYNC, 2);
        chk("R11 low pulses counted", gcnt, 2);
        chk("R11 word while low pulse mode", got[1], SYNC);
        edge_rise = 1'b1;
        @(negedge clk);
        chk("R11 idle level low", wstb, 0);
    endtask

    task automatic t_oe();
        out_en = 1'b0;
        @(negedge clk);
        chk("R9 lock kept", lock_n, 0);
        chk("R9 word blank", word, 0);
        gcnt = 0;
        send_frames(SYNC, 2);
        chk("R9 no strobes", gcnt, 0);
        chk("R9 lock still shown", lock_n, 0);
        out_en = 1'b1;
        @(negedge clk);
        chk("R9 word restored", word, SYNC);
    endtask

    task automatic t_loss();
        for (int i = 0; i < 3; i++) send_frame(10'h000, 1'b0, 1'b0);
        chk("R5 three bad frames tolerated", lock_n, 0);
        send_frame(SYNC);
        for (int i = 0; i < 3; i++) send_frame(10'h000, 1'b0, 1'b0);
        chk("R5 good frame cleared run", lock_n, 0);
        send_frame(10'h000, 1'b0, 1'b0);
        chk("R5 fourth bad frame drops", lock_n, 1);
        chk("R8 word blank after loss", word, 0);
        send_frames(SYNC, 8);
        chk("R6 counters cleared after loss", lock_n, 1);
        send_frame(SYNC);
        chk("R6 relock after nine", lock_n, 0);
    endtask

    task automatic t_power();
        @(negedge clk);
        pwr_up = 1'b0;
        @(negedge clk);
        chk("R10 lock_n high in powerdown", lock_n, 1);
        chk("R10 word blank in powerdown", word, 0);
        chk("R10 wstb low in powerdown", wstb, 0);
        send_frames(SYNC, 2);
        chk("R10 bits ignored in powerdown", lock_n, 1);
        pwr_up = 1'b1;
        send_frames(SYNC, 8);
        chk("R10 full search after run-up", lock_n, 1);
        send_frame(SYNC);
        chk("R10 lock after run-up", lock_n, 0);
    endtask

    task automatic t_rmt();
        power_cycle();
        send_frames(RMT, 20);
        chk("R3 no lock with two candidates", lock_n, 1);
        send_frame(SYNC);
        chk("R3 rival still saturated", lock_n, 1);
        send_frame(SYNC);
        chk("R3 lock once rival breaks", lock_n, 0);
    endtask

    task automatic t_random();
        int n;
        logic [9:0] v [5];
        power_cycle();
        for (int i = 0; i < 8; i++) begin
            next_lf();
            send_frame(lf);
        end
        chk("R4 no lock before 9th frame", lock_n, 1);
        n = 8;
        while (lock_n && n < 16) begin
            next_lf();
            send_frame(lf);
            n++;
        end
        chk("R4 random data locks", lock_n, 0);
        gcnt = 0;
        for (int i = 0; i < 5; i++) begin
            next_lf();
            v[i] = lf;
            send_frame(lf);
        end
        chk("R4 strobes on random data", gcnt, 5);
        for (int k = 1; k < 5; k++) chk("R4 R7 random word", got[k], v[k-1]);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sync_lock();
        t_words();
        t_edge();
        t_oe();
        t_loss();
        t_power();
        t_rmt();
        t_random();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule